// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the power management control and status word of a bridge's configuration space, together with the read-only extension byte and the data byte that follow it in the same dword. Writes arrive as byte-enabled dwords, and reads are combinational from the stored state. Configuration inputs, which a boot-time loader drives, set several things: whether the optional intermediate power states exist, which power states may raise a wake event, whether the data feature is present, the eight data bytes, and the scale field. A local processor may also write the scale field.

The block keeps the current power state. It drops any write that asks for a state the configuration does not provide. It also keeps a sticky wake status. That status is set from a synchronized, active-low downstream wake input whenever the current state supports wake, and the enable bit plays no part in setting it. The active-low wake output is driven only when the status is set and the enable bit is 1. A data select index picks one of the preloaded bytes. Indices past the last byte return zero.

Top module: `pm_ctrl_stat_reg`

## Requirements
- R1: After reset, `cfg_rdata` reads 32'h0000_0000 with all preload data bytes nonzero and the scale load ports idle, and `wake_out_n` is 1.
- R2: A write with `cfg_be[0]`=1 whose bits 1:0 carry a supported state loads that state into bits 1:0. The codes are 00 = D0, 01 = D1, 10 = D2 and 11 = D3. Without such a write the state holds.
- R3: D0 and D3 are always supported. D1 is supported only when `pl_d1_ok`=1, and D2 only when `pl_d2_ok`=1. A write of an unsupported code leaves bits 1:0 unchanged.
- R4: Bits 7:2 of `cfg_rdata`, which include the dynamic-data flag at bit 4, always read 0. The extension byte in bits 23:16 always reads 8'h00.
- R5: Bit 8 (wake enable) is loaded from `cfg_wdata[8]` by a write with `cfg_be[1]`=1 when `pl_wake_cap` is not zero. When `pl_wake_cap` is zero, bit 8 reads 0 and writes to it are ignored.
- R6: Bits 12:9 (data select) are loaded from `cfg_wdata[12:9]` by a write with `cfg_be[1]`=1 only while `pl_data_en`=1. While `pl_data_en`=0 they read 0 and writes are ignored.
- R7: While `pl_data_en`=1 and the select value k is below 8, `data_byte` and `cfg_rdata[31:24]` equal `pl_data_bytes[8k+7:8k]`. For select values 8 to 15, or while `pl_data_en`=0, both read 0.
- R8: Bits 14:13 (scale) ignore configuration writes. A pulse on `pl_scale_ld` loads them from `pl_scale_val`, and a pulse on `lp_scale_we` loads them from `lp_scale_val`. The local port wins when both pulse in the same cycle.
- R9: Bit 15 (wake status) becomes 1 on the third rising edge after `wake_in_n` goes low if `pl_wake_cap[state]` is 1, whatever the value of bit 8. While the current state's capability bit is 0 it does not set.
- R10: A write with `cfg_be[1]`=1 and `cfg_wdata[15]`=1 clears bit 15. With `cfg_wdata[15]`=0 the bit is unchanged.
- R11: When a set condition and a clearing write fall in the same cycle, bit 15 stays 1.
- R12: `wake_out_n` is 0 exactly when bit 15 and bit 8 both read 1.
- R13: A write lane whose `cfg_be` bit is 0 changes none of the fields in that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for this dword |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data: control/status word, extension byte, data byte |
| pl_d1_ok | input | 1 | Preload: D1 supported |
| pl_d2_ok | input | 1 | Preload: D2 supported |
| pl_wake_cap | input | 4 | Preload: wake supported per state, bit n for state code n |
| pl_data_en | input | 1 | Preload: data feature present |
| pl_data_bytes | input | 64 | Preload: data bytes, byte k at bits 8k+7:8k |
| pl_scale_ld | input | 1 | Preload: load scale field |
| pl_scale_val | input | 2 | Preload: scale value |
| lp_scale_we | input | 1 | Local processor: write scale field |
| lp_scale_val | input | 2 | Local processor: scale value |
| wake_in_n | input | 1 | Downstream wake request, active low, asynchronous |
| wake_out_n | output | 1 | Upstream wake request, active low |
| data_byte | output | 8 | Selected data byte |

## Verification
The assertions watch several things on every cycle. The power state and scale fields must hold unless their load conditions are present. An unsupported state code must never be stored. The data select must not move while the data feature is absent. The wake status must set on every qualifying event and clear only on a write-1 with no event in the same cycle. The wake output must never be active unless both status and enable read 1. Several behaviours can only be shown by the bench's scenarios: the exact three-edge latency of the synchronizer, that wake status ignores the enable bit, the byte picked for each select index, the priority of the local scale port, and what happens to a field whose byte enable is clear.

// File: rtl/pmcsr_pkg.sv
// Shared field positions, state encoding and helpers for the power
// management control/status register. Assumes the 16-bit word layout
// fixed by the configuration space and a 4-bit data select field.
package pmcsr_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pwr_state_e;

    localparam int STATE_LSB    = 0;
    localparam int WAKE_EN_BIT  = 8;
    localparam int SEL_LSB      = 9;
    localparam int SEL_W        = 4;
    localparam int SCALE_LSB    = 13;
    localparam int WAKE_STS_BIT = 15;
    localparam int EXT_LSB      = 16;
    localparam int DATA_LSB     = 24;

    // Returns 1 when the given state code may be entered.
    function automatic logic state_is_supported(input logic [1:0] code,
                                                input logic d1_ok,
                                                input logic d2_ok);
        case (code)
            2'b01:   return d1_ok;
            2'b10:   return d2_ok;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pmcsr_sync.sv
// Multi-flop synchronizer for one asynchronous level input.
// Assumes the input is slow compared with clk; resets to RESET_VAL.
module pmcsr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pmcsr_state.sv
// Power state, data select and scale fields. Drops writes of
// unsupported power states and of the data select while the data
// feature is absent; scale is loaded only from its side ports.
module pmcsr_state
    import pmcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [1:0]       st_code,
    input  logic [SEL_W-1:0] sel_val,
    input  logic             d1_ok,
    input  logic             d2_ok,
    input  logic             data_en,
    input  logic             pl_ld,
    input  logic [1:0]       pl_val,
    input  logic             lp_we,
    input  logic [1:0]       lp_val,
    output pwr_state_e       state_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [1:0]       scale_q
);

    logic st_ok;
    assign st_ok = state_is_supported(st_code, d1_ok, d2_ok);

    // Power state: load only supported codes.
    always_ff @(posedge clk) begin
        if (!rst_n)              state_q <= PS_D0;
        else if (wr_lo && st_ok) state_q <= pwr_state_e'(st_code);
    end

    // Data select: writable only when the data feature is present.
    always_ff @(posedge clk) begin
        if (!rst_n)                sel_q <= '0;
        else if (wr_hi && data_en) sel_q <= sel_val;
    end

    // Scale: local processor port has priority over preload.
    always_ff @(posedge clk) begin
        if (!rst_n)     scale_q <= 2'b00;
        else if (lp_we) scale_q <= lp_val;
        else if (pl_ld) scale_q <= pl_val;
    end

    a_r3_bad_state_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !state_is_supported(st_code, d1_ok, d2_ok)) |=> $stable(state_q));

    a_r2_state_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(state_q));

    a_r6_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> $stable(sel_q));

    a_r8_scale_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(pl_ld || lp_we) |=> $stable(scale_q));

endmodule

// File: rtl/pmcsr_data_mux.sv
// Selects one preloaded data byte by index. Indices at or above
// NUM_BYTES, or a disabled feature, give zero.
module pmcsr_data_mux
    import pmcsr_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int BUS_W    = 8 * NUM_BYTES
) (
    input  logic             feat_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [BUS_W-1:0] bytes_in,
    output logic [7:0]       byte_o
);

    // Pick the matching byte; default zero.
    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (feat_en && sel == SEL_W'(k)) byte_o = bytes_in[k*8 +: 8];
        end
    end

endmodule

// File: rtl/pmcsr_wake.sv
// Wake enable, sticky wake status and active-low wake output.
// Assumes wake_n_sync is already synchronized. Status sets on a
// qualifying event regardless of enable; set beats a same-cycle clear.
module pmcsr_wake
    import pmcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_n_sync,
    input  logic [3:0] cap,
    input  pwr_state_e state,
    input  logic       wr_hi,
    input  logic       en_bit,
    input  logic       clr_bit,
    output logic       en_eff,
    output logic       status_q,
    output logic       wake_out_n
);

    logic any_cap;
    logic set_evt;
    logic clr_evt;
    logic en_q;

    assign any_cap = |cap;
    assign set_evt = !wake_n_sync && cap[state];
    assign clr_evt = wr_hi && clr_bit;

    // Sticky status: set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (set_evt) status_q <= 1'b1;
        else if (clr_evt) status_q <= 1'b0;
    end

    // Enable bit: writable only when some state supports wake.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (wr_hi && any_cap) en_q <= en_bit;
    end

    assign en_eff     = en_q && any_cap;
    assign wake_out_n = !(status_q && en_eff);

    a_r9_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> status_q);

    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !status_q);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !clr_evt) |=> status_q);

    a_r5_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !any_cap) |=> $stable(en_q));

endmodule

// File: rtl/pm_ctrl_stat_reg.sv
// Top of the power management control/status register. Splits the
// byte-enabled write into field updates, synchronizes the wake input
// and assembles the read dword: word in 15:0, extension byte 23:16
// (always zero), data byte 31:24. Reads are combinational.
module pm_ctrl_stat_reg
    import pmcsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_BYTES   = 8,
    localparam int BUS_W      = 8 * NUM_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             pl_d1_ok,
    input  logic             pl_d2_ok,
    input  logic [3:0]       pl_wake_cap,
    input  logic             pl_data_en,
    input  logic [BUS_W-1:0] pl_data_bytes,
    input  logic             pl_scale_ld,
    input  logic [1:0]       pl_scale_val,
    input  logic             lp_scale_we,
    input  logic [1:0]       lp_scale_val,
    input  logic             wake_in_n,
    output logic             wake_out_n,
    output logic [7:0]       data_byte
);

    logic             wr_lo;
    logic             wr_hi;
    logic             wake_n_sync;
    pwr_state_e       state_q;
    logic [SEL_W-1:0] sel_q;
    logic [1:0]       scale_q;
    logic             en_eff;
    logic             status_q;
    logic             unused_ok;

    assign wr_lo     = cfg_wr && cfg_be[0];
    assign wr_hi     = cfg_wr && cfg_be[1];
    assign unused_ok = ^{cfg_wdata[31:16], cfg_wdata[14:13], cfg_wdata[7:2], cfg_be[3:2]};

    pmcsr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_in_n),
        .q     (wake_n_sync)
    );

    pmcsr_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .st_code (cfg_wdata[STATE_LSB +: 2]),
        .sel_val (cfg_wdata[SEL_LSB +: SEL_W]),
        .d1_ok   (pl_d1_ok),
        .d2_ok   (pl_d2_ok),
        .data_en (pl_data_en),
        .pl_ld   (pl_scale_ld),
        .pl_val  (pl_scale_val),
        .lp_we   (lp_scale_we),
        .lp_val  (lp_scale_val),
        .state_q (state_q),
        .sel_q   (sel_q),
        .scale_q (scale_q)
    );

    pmcsr_wake u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_n_sync (wake_n_sync),
        .cap         (pl_wake_cap),
        .state       (state_q),
        .wr_hi       (wr_hi),
        .en_bit      (cfg_wdata[WAKE_EN_BIT]),
        .clr_bit     (cfg_wdata[WAKE_STS_BIT]),
        .en_eff      (en_eff),
        .status_q    (status_q),
        .wake_out_n  (wake_out_n)
    );

    pmcsr_data_mux #(.NUM_BYTES(NUM_BYTES)) u_mux (
        .feat_en  (pl_data_en),
        .sel      (sel_q),
        .bytes_in (pl_data_bytes),
        .byte_o   (data_byte)
    );

    // Assemble the read dword from the field registers.
    always_comb begin
        cfg_rdata                          = 32'h0;
        cfg_rdata[STATE_LSB +: 2]          = state_q;
        cfg_rdata[WAKE_EN_BIT]             = en_eff;
        cfg_rdata[SEL_LSB +: SEL_W]        = pl_data_en ? sel_q : '0;
        cfg_rdata[SCALE_LSB +: 2]          = scale_q;
        cfg_rdata[WAKE_STS_BIT]            = status_q;
        cfg_rdata[DATA_LSB +: 8]           = data_byte;
    end

    a_r12_out_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_out_n |-> (cfg_rdata[WAKE_STS_BIT] && cfg_rdata[WAKE_EN_BIT]));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:2] == 6'b0) && (cfg_rdata[EXT_LSB +: 8] == 8'h00));

    a_r7_upper_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[SEL_LSB + SEL_W - 1]) |-> (data_byte == 8'h00));

endmodule

// File: tb/pm_ctrl_stat_reg_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module pm_ctrl_stat_reg_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        pl_d1_ok, pl_d2_ok, pl_data_en, pl_scale_ld, lp_scale_we;
    logic [3:0]  pl_wake_cap;
    logic [63:0] pl_data_bytes;
    logic [1:0]  pl_scale_val, lp_scale_val;
    logic        wake_in_n;
    logic        wake_out_n;
    logic [7:0]  data_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_ctrl_stat_reg dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_be        (cfg_be),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .pl_d1_ok      (pl_d1_ok),
        .pl_d2_ok      (pl_d2_ok),
        .pl_wake_cap   (pl_wake_cap),
        .pl_data_en    (pl_data_en),
        .pl_data_bytes (pl_data_bytes),
        .pl_scale_ld   (pl_scale_ld),
        .pl_scale_val  (pl_scale_val),
        .lp_scale_we   (lp_scale_we),
        .lp_scale_val  (lp_scale_val),
        .wake_in_n     (wake_in_n),
        .wake_out_n    (wake_out_n),
        .data_byte     (data_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_be    = be;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_be    = 4'h0;
        cfg_wdata = 32'h0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        return 8'((k + 1) * 8'h11);
    endfunction

    task automatic t_reset();
        check("R1 reset rdata", cfg_rdata, 32'h0000_0000);
        check("R1 reset wake_out_n", {31'b0, wake_out_n}, 32'h1);
        check("R4 reserved/ext after reset", {24'b0, cfg_rdata[23:16]} | {26'b0, cfg_rdata[7:2]}, 32'h0);
    endtask

    task automatic t_state();
        pl_d1_ok = 1'b0; pl_d2_ok = 1'b0;
        cfg_write(4'b0001, 32'h0000_00FF);
        check("R2 write D3", {30'b0, cfg_rdata[1:0]}, 32'h3);
        check("R4 reserved low bits after all-ones write", {26'b0, cfg_rdata[7:2]}, 32'h0);
        cfg_write(4'b0001, 32'h0000_0001);
        check("R3 D1 unsupported dropped", {30'b0, cfg_rdata[1:0]}, 32'h3);
        cfg_write(4'b0001, 32'h0000_0002);
        check("R3 D2 unsupported dropped", {30'b0, cfg_rdata[1:0]}, 32'h3);
        pl_d1_ok = 1'b1;
        cfg_write(4'b0001, 32'h0000_0001);
        check("R3 D1 supported accepted", {30'b0, cfg_rdata[1:0]}, 32'h1);
        cfg_write(4'b0001, 32'h0000_0002);
        check("R3 D2 still unsupported", {30'b0, cfg_rdata[1:0]}, 32'h1);
        pl_d2_ok = 1'b1;
        cfg_write(4'b0001, 32'h0000_0002);
        check("R2 D2 accepted", {30'b0, cfg_rdata[1:0]}, 32'h2);
        cfg_write(4'b1110, 32'hFFFF_FF00);
        check("R13 lane 0 disabled keeps state", {30'b0, cfg_rdata[1:0]}, 32'h2);
        check("R4 ext byte after write", {24'b0, cfg_rdata[23:16]}, 32'h0);
        cfg_write(4'b0001, 32'h0000_0000);
        check("R2 back to D0", {30'b0, cfg_rdata[1:0]}, 32'h0);
    endtask

    task automatic t_wake_en();
        pl_wake_cap = 4'b0000;
        cfg_write(4'b0010, 32'h0000_0100);
        check("R5 enable locked when no capability", {31'b0, cfg_rdata[8]}, 32'h0);
        pl_wake_cap = 4'b1001;
        check("R5 ignored write left enable clear", {31'b0, cfg_rdata[8]}, 32'h0);
        cfg_write(4'b0001, 32'h0000_0100);
        check("R13 lane 1 disabled keeps enable", {31'b0, cfg_rdata[8]}, 32'h0);
        cfg_write(4'b0010, 32'h0000_0100);
        check("R5 enable written", {31'b0, cfg_rdata[8]}, 32'h1);
        cfg_write(4'b0010, 32'h0000_0000);
        check("R5 enable cleared", {31'b0, cfg_rdata[8]}, 32'h0);
    endtask

    task automatic t_data();
        pl_data_en = 1'b0;
        cfg_write(4'b0010, 32'h0000_0A00);
        check("R6 select reads 0 when disabled", {28'b0, cfg_rdata[12:9]}, 32'h0);
        check("R7 data 0 when disabled", {24'b0, data_byte}, 32'h0);
        pl_data_en = 1'b1;
        @(negedge clk);
        check("R6 disabled write was dropped", {28'b0, cfg_rdata[12:9]}, 32'h0);
        check("R7 select 0 picks byte 0", {24'b0, data_byte}, {24'b0, exp_byte(0)});
        for (int k = 0; k < 16; k++) begin
            cfg_write(4'b0010, 32'(k) << 9);
            check("R6 select readback", {28'b0, cfg_rdata[12:9]}, 32'(k));
            check("R7 data byte", {24'b0, data_byte}, (k < 8) ? {24'b0, exp_byte(k)} : 32'h0);
            check("R7 data in rdata", {24'b0, cfg_rdata[31:24]}, (k < 8) ? {24'b0, exp_byte(k)} : 32'h0);
        end
        cfg_write(4'b0010, 32'h0000_0600);
        pl_data_en = 1'b0;
        @(negedge clk);
        check("R6 select hidden when feature off", {28'b0, cfg_rdata[12:9]}, 32'h0);
        check("R7 data zero when feature off", {24'b0, data_byte}, 32'h0);
    endtask

    task automatic t_scale();
        @(negedge clk);
        pl_scale_ld = 1'b1; pl_scale_val = 2'd2;
        @(negedge clk);
        pl_scale_ld = 1'b0;
        check("R8 preload scale", {30'b0, cfg_rdata[14:13]}, 32'h2);
        cfg_write(4'b0010, 32'h0000_6000);
        check("R8 config write ignored", {30'b0, cfg_rdata[14:13]}, 32'h2);
        lp_scale_we = 1'b1; lp_scale_val = 2'd1;
        @(negedge clk);
        lp_scale_we = 1'b0;
        check("R8 local write", {30'b0, cfg_rdata[14:13]}, 32'h1);
        pl_scale_ld = 1'b1; pl_scale_val = 2'd3;
        lp_scale_we = 1'b1; lp_scale_val = 2'd0;
        @(negedge clk);
        pl_scale_ld = 1'b0; lp_scale_we = 1'b0;
        check("R8 local wins", {30'b0, cfg_rdata[14:13]}, 32'h0);
    endtask

    task automatic t_wake_status();
        pl_wake_cap = 4'b1001;
        wake_in_n = 1'b0;
        wait_cycles(2);
        check("R9 not yet set after two edges", {31'b0, cfg_rdata[15]}, 32'h0);
        wait_cycles(1);
        check("R9 set after three edges, enable off", {31'b0, cfg_rdata[15]}, 32'h1);
        check("R12 no wake out while disabled", {31'b0, wake_out_n}, 32'h1);
        wake_in_n = 1'b1;
        wait_cycles(4);
        cfg_write(4'b0010, 32'h0000_0000);
        check("R10 writing 0 keeps status", {31'b0, cfg_rdata[15]}, 32'h1);
        cfg_write(4'b0010, 32'h0000_0100);
        check("R12 wake out asserted", {31'b0, wake_out_n}, 32'h0);
        cfg_write(4'b0001, 32'h0000_8000);
        check("R13 clear in disabled lane ignored", {31'b0, cfg_rdata[15]}, 32'h1);
        cfg_write(4'b0010, 32'h0000_8100);
        check("R10 write 1 clears", {31'b0, cfg_rdata[15]}, 32'h0);
        check("R12 wake out released", {31'b0, wake_out_n}, 32'h1);
        pl_wake_cap = 4'b1000;
        wake_in_n = 1'b0;
        wait_cycles(5);
        check("R9 no set when state lacks capability", {31'b0, cfg_rdata[15]}, 32'h0);
        cfg_write(4'b0001, 32'h0000_0003);
        @(negedge clk);
        check("R9 set once in capable state", {31'b0, cfg_rdata[15]}, 32'h1);
        wake_in_n = 1'b1;
        wait_cycles(4);
        cfg_write(4'b0011, 32'h0000_8000);
        check("R10 cleared, enable written 0", {31'b0, cfg_rdata[15]}, 32'h0);
        pl_wake_cap = 4'b1001;
    endtask

    task automatic t_set_wins();
        wake_in_n = 1'b0;
        wait_cycles(3);
        check("R11 precondition set", {31'b0, cfg_rdata[15]}, 32'h1);
        cfg_write(4'b0010, 32'h0000_8000);
        check("R11 set beats clear", {31'b0, cfg_rdata[15]}, 32'h1);
        wake_in_n = 1'b1;
        wait_cycles(4);
        cfg_write(4'b0010, 32'h0000_8000);
        check("R11 clear after event ends", {31'b0, cfg_rdata[15]}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
        pl_d1_ok = 1'b0; pl_d2_ok = 1'b0; pl_wake_cap = 4'b0000;
        pl_data_en = 1'b0; pl_data_bytes = 64'h8877_6655_4433_2211;
        pl_scale_ld = 1'b0; pl_scale_val = 2'd0;
        lp_scale_we = 1'b0; lp_scale_val = 2'd0;
        wake_in_n = 1'b1;
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_state();
        t_wake_en();
        t_data();
        t_scale();
        t_wake_status();
        t_set_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule